// File: doc/BRIEF.md
# Pipelined Instruction Fetch Unit

This block is the first stage of a five-stage in-order pipeline. It keeps a program counter that holds only the word part of a byte address, because instructions are 32 bits wide and always word aligned. Each cycle it puts the fetch address on a shared byte-addressed bus and latches the returned word into the instruction register. At that same edge the counter moves forward by one word. As a result, while an instruction sits in the instruction register, the counter already points four bytes past it.

Three events change the sequential flow. When the memory stage needs the shared bus for a load or store, fetch gives up the bus for that cycle. The fetch request drops, and the counter and instruction register both hold, so the stall costs one cycle. When a redirect arrives, for example a resolved branch target, the counter loads the target and the instruction register is filled with a no-op, which discards the fetched word. When an exception is raised, a call instruction chosen by the exception cause replaces the fetched word in the instruction register. The pipeline then performs a subroutine call into the service routine.

The three events are ranked. An exception wins over a redirect. A redirect wins over sequential flow. A memory-stage stall only suppresses the sequential step.

Top module: `ifu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the PC is set to `START_ADDR` (byte 0x000100 by default) and the instruction register to `NOP_WORD` (0xF0000000 by default). `bus_req` is high after reset.
- R2: `bus_addr` and `pc_byte` both show the current PC as a 24-bit byte address. Their two low bits are always zero.
- R3: In a cycle with no stall, no redirect and no exception, the instruction register takes `bus_rdata` at the clock edge, and the PC advances by 4 bytes at the same edge.
- R4: After a sequential capture, `pc_byte` equals the byte address the word in the instruction register was fetched from, plus 4.
- R5: While `mem_busy` is high, `bus_req` is low. If there is no redirect and no exception in that cycle, the PC and the instruction register keep their values at the edge.
- R6: When `redir_valid` is high and `exc_valid` is low, the PC loads `redir_addr` with its two low bits cleared, and the instruction register loads `NOP_WORD`. This happens even while `mem_busy` is high.
- R7: When `exc_valid` is high, the instruction register loads the trap word for `exc_cause`: cause 0 selects `TRAP_WORDS[31:0]` (default 0xB8000040) and cause 1 selects `TRAP_WORDS[63:32]` (default 0xB8000080). The PC holds its value, whatever the state of `redir_valid` and `mem_busy`.
- R8: The two low bits of `redir_addr` have no effect on the PC.
- R9: The PC wraps from byte address 0xFFFFFC to 0x000000 on a sequential step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_busy | input | 1 | Memory stage owns the bus this cycle |
| redir_valid | input | 1 | Load the PC from `redir_addr` |
| redir_addr | input | 24 | Redirect byte address |
| exc_valid | input | 1 | Inject a trap call word into the instruction register |
| exc_cause | input | 1 | Selects which trap word is injected |
| bus_rdata | input | 32 | Word returned by the bus for `bus_addr` |
| bus_req | output | 1 | Fetch request, low while the memory stage owns the bus |
| bus_addr | output | 24 | Fetch byte address |
| pc_byte | output | 24 | Current PC as a byte address |
| ir | output | 32 | Instruction register |

## Verification
On every cycle, the assertions check the cycle-to-cycle relations of the counter: a one-word step in sequential flow, holding during stalls and exceptions, and loading a redirect target. They also check that the instruction register is unchanged across a stall cycle. Only the bench scenarios can show the data side, which needs an outside memory model to predict. Those scenarios cover which fetched word lands in the instruction register, the exact trap word chosen for each cause, the no-op fill after a redirect, the handling of unaligned redirect bits and the wrap at the top of the address space.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    // Source for the next PC / IR update
    typedef enum logic [1:0] {
        NXT_HOLD  = 2'd0,
        NXT_SEQ   = 2'd1,
        NXT_REDIR = 2'd2,
        NXT_TRAP  = 2'd3
    } nxt_e;

    typedef struct packed {
        nxt_e sel;
        logic fetch_req;
    } ifu_ctl_t;

    // Priority: trap > redirect > stall > sequential
    function automatic nxt_e pick_next(input logic exc, input logic redir, input logic busy);
        if (exc)        return NXT_TRAP;
        else if (redir) return NXT_REDIR;
        else if (busy)  return NXT_HOLD;
        else            return NXT_SEQ;
    endfunction

endpackage

// File: rtl/ifu_sel.sv
module ifu_sel
    import ifu_pkg::*;
(
    input  logic     mem_busy,
    input  logic     redir_valid,
    input  logic     exc_valid,
    output ifu_ctl_t ctl
);
    always_comb begin
        ctl.sel       = pick_next(exc_valid, redir_valid, mem_busy);
        ctl.fetch_req = ~mem_busy;
    end
endmodule

// File: rtl/ifu_pc.sv
module ifu_pc
    import ifu_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PC_W    = ADDR_W - 2,
    parameter logic [PC_W-1:0] START_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  nxt_e              sel,
    input  logic [ADDR_W-1:0] redir_addr,
    output logic [PC_W-1:0]   pc_q
);
    logic [PC_W-1:0] redir_pc;
    logic [PC_W-1:0] pc_d;

    assign redir_pc = PC_W'(redir_addr >> 2);

    always_comb begin
        unique case (sel)
            NXT_SEQ:   pc_d = pc_q + PC_W'(1);
            NXT_REDIR: pc_d = redir_pc;
            NXT_TRAP:  pc_d = pc_q;
            default:   pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= START_PC;
        else     pc_q <= pc_d;
    end

    AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        sel == NXT_SEQ |=> pc_q == $past(pc_q) + PC_W'(1)); // R3
endmodule

// File: rtl/ifu_ir.sv
module ifu_ir
    import ifu_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int CAUSE_W = 1,
    parameter int N_CAUSE = 1 << CAUSE_W,
    parameter logic [INSTR_W-1:0] NOP_WORD = '0,
    parameter logic [N_CAUSE*INSTR_W-1:0] TRAP_WORDS = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  nxt_e               sel,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [INSTR_W-1:0] fetch_word,
    output logic [INSTR_W-1:0] ir_q
);
    logic [INSTR_W-1:0] trap_tbl [N_CAUSE];
    logic [INSTR_W-1:0] ir_d;

    for (genvar g = 0; g < N_CAUSE; g++) begin : g_trap
        assign trap_tbl[g] = TRAP_WORDS[g*INSTR_W +: INSTR_W];
    end

    always_comb begin
        unique case (sel)
            NXT_SEQ:   ir_d = fetch_word;
            NXT_REDIR: ir_d = NOP_WORD;
            NXT_TRAP:  ir_d = trap_tbl[cause];
            default:   ir_d = ir_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ir_q <= NOP_WORD;
        else     ir_q <= ir_d;
    end

    AST_IR_SQUASH: assert property (@(posedge clk) disable iff (rst)
        sel == NXT_REDIR |=> ir_q == NOP_WORD); // R6
endmodule

// File: rtl/ifu_top.sv
module ifu_top
    import ifu_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int INSTR_W = 32,
    parameter int CAUSE_W = 1,
    parameter logic [ADDR_W-1:0]  START_ADDR = 24'h000100,
    parameter logic [INSTR_W-1:0] NOP_WORD   = 32'hF000_0000,
    parameter logic [(1<<CAUSE_W)*INSTR_W-1:0] TRAP_WORDS = {32'hB800_0080, 32'hB800_0040}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_busy,
    input  logic               redir_valid,
    input  logic [ADDR_W-1:0]  redir_addr,
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [INSTR_W-1:0] bus_rdata,
    output logic               bus_req,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [ADDR_W-1:0]  pc_byte,
    output logic [INSTR_W-1:0] ir
);
    localparam int PC_W    = ADDR_W - 2;
    localparam int N_CAUSE = 1 << CAUSE_W;
    localparam logic [PC_W-1:0] START_PC = START_ADDR[ADDR_W-1:2];

    ifu_ctl_t        ctl;
    logic [PC_W-1:0] pc_q;

    ifu_sel u_sel (
        .mem_busy    (mem_busy),
        .redir_valid (redir_valid),
        .exc_valid   (exc_valid),
        .ctl         (ctl)
    );

    ifu_pc #(.ADDR_W(ADDR_W), .PC_W(PC_W), .START_PC(START_PC)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .sel        (ctl.sel),
        .redir_addr (redir_addr),
        .pc_q       (pc_q)
    );

    ifu_ir #(.INSTR_W(INSTR_W), .CAUSE_W(CAUSE_W), .N_CAUSE(N_CAUSE),
             .NOP_WORD(NOP_WORD), .TRAP_WORDS(TRAP_WORDS)) u_ir (
        .clk        (clk),
        .rst        (rst),
        .sel        (ctl.sel),
        .cause      (exc_cause),
        .fetch_word (bus_rdata),
        .ir_q       (ir)
    );

    assign bus_req  = ctl.fetch_req;
    assign bus_addr = {pc_q, 2'b00};
    assign pc_byte  = {pc_q, 2'b00};

    AST_STALL_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_busy && !redir_valid && !exc_valid |=> $stable(pc_q)); // R5
    AST_IDLE_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_req && !redir_valid && !exc_valid |=> $stable(ir)); // R5
    AST_REDIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        redir_valid && !exc_valid |=> pc_q == $past(redir_addr[ADDR_W-1:2])); // R6
    AST_TRAP_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> $stable(pc_q)); // R7
endmodule

// File: tb/test_ifu_top.sv
module test_ifu_top;
    localparam logic [31:0] NOP   = 32'hF000_0000;
    localparam logic [31:0] TRAP0 = 32'hB800_0040;
    localparam logic [31:0] TRAP1 = 32'hB800_0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_busy = 1'b0, redir_valid = 1'b0, exc_valid = 1'b0;
    logic [23:0] redir_addr = '0;
    logic [0:0]  exc_cause = '0;
    logic [31:0] bus_rdata;
    logic        bus_req;
    logic [23:0] bus_addr, pc_byte;
    logic [31:0] ir;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Simple bus model: word tagged with its address
    assign bus_rdata = bus_req ? {8'hA5, bus_addr} : 32'hDEAD_BEEF;

    ifu_top i_ifu_top (
        .clk(clk), .rst(rst), .mem_busy(mem_busy), .redir_valid(redir_valid),
        .redir_addr(redir_addr), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
        .pc_byte(pc_byte), .ir(ir)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R1 pc", {8'h0, pc_byte}, 32'h0000_0100);
        chk("R1 ir", ir, NOP);
        chk("R1 req", {31'b0, bus_req}, 32'd1);
        chk("R2 addr", {8'h0, bus_addr}, 32'h0000_0100);
        rst = 1'b0;
    endtask

    task automatic t_sequential();
        for (int i = 0; i < 4; i++) begin
            logic [23:0] a;
            a = bus_addr;
            tick();
            chk("R3 ir", ir, {8'hA5, a});
            chk("R4 pc", {8'h0, pc_byte}, {8'h0, a + 24'd4});
            chk("R2 addr", {8'h0, bus_addr}, {8'h0, pc_byte});
        end
    endtask

    task automatic t_stall();
        logic [23:0] p;
        logic [31:0] w;
        p = pc_byte; w = ir;
        mem_busy = 1'b1;
        #1 chk("R5 req", {31'b0, bus_req}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 pc", {8'h0, pc_byte}, {8'h0, p});
            chk("R5 ir", ir, w);
        end
        mem_busy = 1'b0;
        tick();
        chk("R3 after stall", ir, {8'hA5, p});
    endtask

    task automatic t_redirect();
        mem_busy = 1'b1; redir_valid = 1'b1; redir_addr = 24'h001237;
        tick();
        mem_busy = 1'b0; redir_valid = 1'b0;
        chk("R6 R8 pc", {8'h0, pc_byte}, 32'h0000_1234);
        chk("R6 ir", ir, NOP);
        tick();
        chk("R6 ir follow", ir, 32'hA500_1234);
        chk("R6 pc follow", {8'h0, pc_byte}, 32'h0000_1238);
    endtask

    task automatic t_exception();
        logic [23:0] p;
        p = pc_byte;
        exc_valid = 1'b1; exc_cause = 1'b0;
        redir_valid = 1'b1; redir_addr = 24'h004000; mem_busy = 1'b1;
        tick();
        redir_valid = 1'b0; mem_busy = 1'b0;
        chk("R7 ir cause0", ir, TRAP0);
        chk("R7 pc hold", {8'h0, pc_byte}, {8'h0, p});
        exc_cause = 1'b1;
        tick();
        exc_valid = 1'b0;
        chk("R7 ir cause1", ir, TRAP1);
        chk("R7 pc hold2", {8'h0, pc_byte}, {8'h0, p});
        tick();
        chk("R3 after trap", ir, {8'hA5, p});
    endtask

    task automatic t_wrap();
        redir_valid = 1'b1; redir_addr = 24'hFFFFFF;
        tick();
        redir_valid = 1'b0;
        chk("R8 pc", {8'h0, pc_byte}, 32'h00FF_FFFC);
        tick();
        chk("R9 ir", ir, 32'hA5FF_FFFC);
        chk("R9 pc", {8'h0, pc_byte}, 32'h0);
    endtask

    initial begin
        #2;
        t_reset();
        t_sequential();
        t_stall();
        t_redirect();
        t_exception();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule